// File: doc/BRIEF.md
# Test Access Instruction Decoder

This block holds the active instruction of a boundary-scan test access port and turns it into two decisions. The first is which serial data register sits between the test data input and the test data output: the identification register, the single-bit bypass register, or the boundary chain. The boundary chain itself is outside the block and is reached through a serial return input. The second decision is the mode of the chip's output bus: normal function, forced high impedance, or driven from preloaded boundary values.

The controller state machine sits outside the block. It supplies one-cycle strobes for its Test-Logic-Reset, Capture-IR, Shift-IR, Update-IR, Capture-DR and Shift-DR states, all timed to the rising edge of the test clock. Serial registers move on the rising edge. A newly shifted instruction becomes active on the falling edge of the cycle that carries the Update-IR strobe. Both a power-up reset and Test-Logic-Reset make the identification instruction active. The serial output is given unregistered, so the surrounding port logic can retime it.

Top module: `tap_instr_decoder`

## Requirements
- R1: After power-up reset, and on the falling clock edge of any cycle with the Test-Logic-Reset strobe high, the active instruction becomes identification: `chain_sel` = 00 and `bus_mode` = 00.
- R2: Under identification (opcode 001), Capture-DR loads the ID_W-bit identification value. Each Shift-DR cycle then presents the value least significant bit first on `tdo`, and `tdi` bits follow it out ID_W cycles later.
- R3: Under bypass (opcode 111), `chain_sel` = 01. The one-bit register loads 0 at Capture-DR, so the first shifted bit on `tdo` is 0. After that, `tdo` repeats `tdi` one cycle late.
- R4: The opcodes 011, 101 and 110, and any opcode with a nonzero bit above bit 2, act exactly like bypass: `chain_sel` = 01 and `bus_mode` = 00.
- R5: Under external test (opcode 000), `chain_sel` = 10 (boundary), `bus_mode` = 10 (drive from preload), and `tdo` follows `bnd_so`.
- R6: Under sample/preload (opcode 100), `chain_sel` = 10, `bus_mode` = 00, and `tdo` follows `bnd_so`.
- R7: Under sample-with-high-Z (opcode 010), `chain_sel` = 10 and `bus_mode` = 01. The mode stays 01 through any number of data scans until another instruction takes effect.
- R8: Capture-IR loads the instruction shift register with 0…01 (bit 0 = 1, all other bits 0). During Shift-IR, `tdo` gives bit 0, and `tdi` enters at the top bit, so the opcode is shifted in least significant bit first.
- R9: Capturing or shifting an instruction changes neither `chain_sel` nor `bus_mode`. They change only after the falling edge of an Update-IR or Test-Logic-Reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-up reset, active low |
| tlr | input | 1 | Test-Logic-Reset state strobe |
| capture_ir | input | 1 | Capture-IR state strobe |
| shift_ir | input | 1 | Shift-IR state strobe |
| update_ir | input | 1 | Update-IR state strobe |
| capture_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| tdi | input | 1 | Serial test data in |
| bnd_so | input | 1 | Serial return from the external boundary chain |
| tdo | output | 1 | Serial output of the IR (in Shift-IR) or of the selected data register |
| chain_sel | output | 2 | Selected data register: 00 identification, 01 bypass, 10 boundary |
| bus_mode | output | 2 | Output bus mode: 00 normal, 01 high-Z, 10 drive from preload |

## Verification
In the cycle that carries Update-IR, two things happen together. The new instruction takes effect on the falling edge, while the instruction shift register still holds the bits that were just shifted and the previous instruction's data register and bus mode are still in force. The bench loads random opcodes, including reserved ones, directly after each other. During every shift cycle it checks that the old selection and mode remain unchanged. In the same cycle as the update strobe, after the falling edge, it checks that the new values are in place. A sample-with-high-Z instruction is also followed by data scans and by a Test-Logic-Reset strobe, to check that the float mode holds until an instruction change ends it.

// File: rtl/tapdec_pkg.sv
package tapdec_pkg;
   localparam logic [1:0] CH_IDENT    = 2'd0;
   localparam logic [1:0] CH_BYPASS   = 2'd1;
   localparam logic [1:0] CH_BOUNDARY = 2'd2;

   localparam logic [1:0] BUS_NORMAL  = 2'd0;
   localparam logic [1:0] BUS_FLOAT   = 2'd1;
   localparam logic [1:0] BUS_DRIVE   = 2'd2;

   localparam logic [2:0] OP_EXTEST   = 3'b000;
   localparam logic [2:0] OP_IDENT    = 3'b001;
   localparam logic [2:0] OP_SAMPLE_Z = 3'b010;
   localparam logic [2:0] OP_SAMPLE   = 3'b100;
   localparam logic [2:0] OP_BYPASS   = 3'b111;
endpackage

// File: rtl/tapdec_ir.sv
module tapdec_ir #(
   parameter int IR_W = 3
) (
   input  logic            tck,
   input  logic            por_n,
   input  logic            tlr,
   input  logic            capture_ir,
   input  logic            shift_ir,
   input  logic            update_ir,
   input  logic            tdi,
   output logic            ir_so,
   output logic [IR_W-1:0] active_op
);
   import tapdec_pkg::*;

   localparam logic [IR_W-1:0] CAP_PATTERN = IR_W'(2'b01);
   localparam logic [IR_W-1:0] RESET_OP    = IR_W'(OP_IDENT);

   logic [IR_W-1:0] ir_sr;

   // instruction shift register, rising edge
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)           ir_sr <= '0;
      else if (capture_ir)  ir_sr <= CAP_PATTERN;
      else if (shift_ir)    ir_sr <= {tdi, ir_sr[IR_W-1:1]};
   end

   // active instruction, falling edge
   always_ff @(negedge tck or negedge por_n) begin
      if (!por_n)          active_op <= RESET_OP;
      else if (tlr)        active_op <= RESET_OP;
      else if (update_ir)  active_op <= ir_sr;
   end

   assign ir_so = ir_sr[0];

   p_capture_pattern_r8: assert property (@(posedge tck) disable iff (!por_n)
      capture_ir |=> (ir_sr == CAP_PATTERN));

   p_shift_in_top_r8: assert property (@(posedge tck) disable iff (!por_n)
      (shift_ir && !capture_ir) |=> (ir_sr[IR_W-1] == $past(tdi)));

   p_op_hold_r9: assert property (@(posedge tck) disable iff (!por_n)
      (!update_ir && !tlr) |-> $stable(active_op));

   p_tlr_ident_r1: assert property (@(posedge tck) disable iff (!por_n)
      tlr |-> (active_op == RESET_OP));
endmodule

// File: rtl/tapdec_decode.sv
module tapdec_decode #(
   parameter int IR_W = 3
) (
   input  logic [IR_W-1:0] op,
   output logic [1:0]      chain,
   output logic [1:0]      mode
);
   import tapdec_pkg::*;

   logic upper_clear;

   generate
      if (IR_W > 3) begin : g_wide
         assign upper_clear = ~|op[IR_W-1:3];
      end else begin : g_narrow
         assign upper_clear = 1'b1;
      end
   endgenerate

   always_comb begin
      chain = CH_BYPASS;
      mode  = BUS_NORMAL;
      if (upper_clear) begin
         case (op[2:0])
            OP_EXTEST:   begin chain = CH_BOUNDARY; mode = BUS_DRIVE; end
            OP_IDENT:    chain = CH_IDENT;
            OP_SAMPLE_Z: begin chain = CH_BOUNDARY; mode = BUS_FLOAT; end
            OP_SAMPLE:   chain = CH_BOUNDARY;
            default:     chain = CH_BYPASS;
         endcase
      end
   end
endmodule

// File: rtl/tapdec_dr.sv
module tapdec_dr #(
   parameter int              ID_W     = 32,
   parameter logic [ID_W-1:0] ID_VALUE = '1
) (
   input  logic       tck,
   input  logic       por_n,
   input  logic       capture_dr,
   input  logic       shift_dr,
   input  logic       tdi,
   input  logic [1:0] chain,
   output logic       id_so,
   output logic       byp_so
);
   import tapdec_pkg::*;

   logic [ID_W-1:0] id_sr;
   logic            byp_q;

   generate
      if (ID_W > 1) begin : g_id_multi
         always_ff @(posedge tck or negedge por_n) begin
            if (!por_n)                                id_sr <= ID_VALUE;
            else if (capture_dr && chain == CH_IDENT)  id_sr <= ID_VALUE;
            else if (shift_dr && chain == CH_IDENT)    id_sr <= {tdi, id_sr[ID_W-1:1]};
         end
      end else begin : g_id_single
         always_ff @(posedge tck or negedge por_n) begin
            if (!por_n)                                id_sr <= ID_VALUE;
            else if (capture_dr && chain == CH_IDENT)  id_sr <= ID_VALUE;
            else if (shift_dr && chain == CH_IDENT)    id_sr <= tdi;
         end
      end
   endgenerate

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                                 byp_q <= 1'b0;
      else if (capture_dr)                        byp_q <= 1'b0;
      else if (shift_dr && chain == CH_BYPASS)    byp_q <= tdi;
   end

   assign id_so  = id_sr[0];
   assign byp_so = byp_q;

   p_id_capture_r2: assert property (@(posedge tck) disable iff (!por_n)
      (capture_dr && chain == CH_IDENT) |=> (id_so == ID_VALUE[0]));

   p_bypass_capture_r3: assert property (@(posedge tck) disable iff (!por_n)
      capture_dr |=> (byp_so == 1'b0));

   p_bypass_delay_r3: assert property (@(posedge tck) disable iff (!por_n)
      (shift_dr && !capture_dr && chain == CH_BYPASS) |=> (byp_so == $past(tdi)));
endmodule

// File: rtl/tap_instr_decoder.sv
module tap_instr_decoder #(
   parameter int              IR_W     = 3,
   parameter int              ID_W     = 32,
   parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_E0F3
) (
   input  logic       tck,
   input  logic       por_n,
   input  logic       tlr,
   input  logic       capture_ir,
   input  logic       shift_ir,
   input  logic       update_ir,
   input  logic       capture_dr,
   input  logic       shift_dr,
   input  logic       tdi,
   input  logic       bnd_so,
   output logic       tdo,
   output logic [1:0] chain_sel,
   output logic [1:0] bus_mode
);
   import tapdec_pkg::*;

   generate
      if (IR_W < 3) begin : g_bad_ir_w
         $error("tap_instr_decoder: IR_W must be at least 3");
      end
      if (ID_W < 1) begin : g_bad_id_w
         $error("tap_instr_decoder: ID_W must be at least 1");
      end
   endgenerate

   logic [IR_W-1:0] active_op;
   logic            ir_so;
   logic            id_so;
   logic            byp_so;

   tapdec_ir #(.IR_W(IR_W)) i_ir (
      .tck        (tck),
      .por_n      (por_n),
      .tlr        (tlr),
      .capture_ir (capture_ir),
      .shift_ir   (shift_ir),
      .update_ir  (update_ir),
      .tdi        (tdi),
      .ir_so      (ir_so),
      .active_op  (active_op)
   );

   tapdec_decode #(.IR_W(IR_W)) i_decode (
      .op    (active_op),
      .chain (chain_sel),
      .mode  (bus_mode)
   );

   tapdec_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) i_dr (
      .tck        (tck),
      .por_n      (por_n),
      .capture_dr (capture_dr),
      .shift_dr   (shift_dr),
      .tdi        (tdi),
      .chain      (chain_sel),
      .id_so      (id_so),
      .byp_so     (byp_so)
   );

   always_comb begin
      if (shift_ir)                       tdo = ir_so;
      else if (chain_sel == CH_IDENT)     tdo = id_so;
      else if (chain_sel == CH_BOUNDARY)  tdo = bnd_so;
      else                                tdo = byp_so;
   end

   p_float_hold_r7: assert property (@(posedge tck) disable iff (!por_n)
      (!update_ir && !tlr && $past(bus_mode) == BUS_FLOAT) |-> (bus_mode == BUS_FLOAT));

   p_mode_shift_hold_r9: assert property (@(posedge tck) disable iff (!por_n)
      (shift_ir || capture_ir) |-> ($stable(bus_mode) && $stable(chain_sel)));

   p_boundary_path_r5: assert property (@(posedge tck) disable iff (!por_n)
      (!shift_ir && chain_sel == CH_BOUNDARY) |-> (tdo == bnd_so));
endmodule

// File: tb/test_tap_instr_decoder.sv
module test_tap_instr_decoder;
   localparam int          CLK_PERIOD = 10;
   localparam int          IR_W = 3;
   localparam int          ID_W = 32;
   localparam logic [31:0] ID_VALUE = 32'h1A5C_E0F3;

   logic tck = 1'b0;
   logic por_n = 1'b0;
   logic tlr = 0, capture_ir = 0, shift_ir = 0, update_ir = 0;
   logic capture_dr = 0, shift_dr = 0, tdi = 0, bnd_so = 0;
   logic       tdo;
   logic [1:0] chain_sel;
   logic [1:0] bus_mode;

   int nchk = 0;
   int nerr = 0;
   logic [2:0] cur_op;

   always #(CLK_PERIOD/2) tck = ~tck;

   tap_instr_decoder #(.IR_W(IR_W), .ID_W(ID_W), .ID_VALUE(ID_VALUE)) i_tap_instr_decoder (
      .tck(tck), .por_n(por_n), .tlr(tlr), .capture_ir(capture_ir),
      .shift_ir(shift_ir), .update_ir(update_ir), .capture_dr(capture_dr),
      .shift_dr(shift_dr), .tdi(tdi), .bnd_so(bnd_so),
      .tdo(tdo), .chain_sel(chain_sel), .bus_mode(bus_mode)
   );

   function automatic logic [1:0] exp_chain(input logic [2:0] op);
      case (op)
         3'b001:                 return 2'd0;
         3'b000, 3'b010, 3'b100: return 2'd2;
         default:                return 2'd1;
      endcase
   endfunction

   function automatic logic [1:0] exp_mode(input logic [2:0] op);
      case (op)
         3'b000:  return 2'd2;
         3'b010:  return 2'd1;
         default: return 2'd0;
      endcase
   endfunction

   function automatic string op_req(input logic [2:0] op);
      case (op)
         3'b000:  return "R5";
         3'b001:  return "R2";
         3'b010:  return "R7";
         3'b100:  return "R6";
         3'b111:  return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge tck);
      #1;
   endtask

   task automatic settle();
      @(negedge tck);
      #2;
   endtask

   task automatic idle();
      tlr = 0; capture_ir = 0; shift_ir = 0; update_ir = 0;
      capture_dr = 0; shift_dr = 0;
   endtask

   task automatic load_ir(input logic [2:0] op);
      logic [1:0] old_ch = chain_sel;
      logic [1:0] old_md = bus_mode;
      tick(); idle(); capture_ir = 1; settle();
      for (int i = 0; i < IR_W; i++) begin
         tick(); idle(); shift_ir = 1; tdi = op[i]; settle();
         chk("R8", tdo, (i == 0) ? 1 : 0);
         chk("R9", {chain_sel, bus_mode}, {old_ch, old_md});
      end
      tick(); idle(); update_ir = 1; settle();
      chk(op_req(op), chain_sel, exp_chain(op));
      chk(op_req(op), bus_mode, exp_mode(op));
      tick(); idle(); settle();
      cur_op = op;
   endtask

   task automatic scan_dr(input int n);
      logic [63:0] hist = '0;
      logic        exp;
      tick(); idle(); capture_dr = 1; settle();
      for (int k = 0; k < n; k++) begin
         tick(); idle(); shift_dr = 1;
         tdi = 1'($urandom); bnd_so = 1'($urandom);
         hist[k] = tdi;
         settle();
         case (exp_chain(cur_op))
            2'd0:    exp = (k < ID_W) ? ID_VALUE[k] : hist[k-ID_W];
            2'd1:    exp = (k == 0) ? 1'b0 : hist[k-1];
            default: exp = bnd_so;
         endcase
         chk(op_req(cur_op), tdo, exp);
      end
      tick(); idle(); settle();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      nerr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      void'($urandom(32'd7741));
      cur_op = 3'b001;
      #(CLK_PERIOD * 2 + 3);
      // R1: reset state
      chk("R1", chain_sel, 2'd0);
      chk("R1", bus_mode, 2'd0);
      por_n = 1'b1;
      settle();
      chk("R1", chain_sel, 2'd0);
      // R2: identification code out after reset
      scan_dr(40);
      // directed: every defined and reserved code once
      for (int c = 0; c < 8; c++) begin
         load_ir(3'(c));
         scan_dr(8);
      end
      // R7: float held across scans, ended by new instruction
      load_ir(3'b010);
      scan_dr(12);
      chk("R7", bus_mode, 2'd1);
      scan_dr(5);
      chk("R7", bus_mode, 2'd1);
      load_ir(3'b100);
      chk("R7", bus_mode, 2'd0);
      // R1: Test-Logic-Reset strobe from float and from bypass
      load_ir(3'b010);
      tick(); idle(); tlr = 1; settle();
      chk("R1", chain_sel, 2'd0);
      chk("R1", bus_mode, 2'd0);
      tick(); idle(); settle();
      cur_op = 3'b001;
      load_ir(3'b111);
      tick(); idle(); tlr = 1; settle();
      chk("R1", chain_sel, 2'd0);
      tick(); idle(); settle();
      cur_op = 3'b001;
      scan_dr(34);
      // random sequence
      for (int r = 0; r < 60; r++) begin
         load_ir(3'($urandom));
         scan_dr(1 + int'($urandom % 40));
      end
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule